// File: doc/BRIEF.md
# Power-Fail Protection and Battery-Status Supervisor

This block decides which memory cycles may reach a battery-backed static RAM, based on the state of the main supply and of two backup cells. It receives digital comparator results: main supply above the full-operation threshold (nominally 4.5 V), main supply above the switchover threshold (nominally 3.0 V), each cell above its minimum level (nominally 2.0 V), and which cell is the stronger. It also receives a one-clock strobe for each memory cycle and a write flag. It returns per-cycle access and write enables, a select that puts the RAM on backup power, a select that picks one of the two cells, and a one-clock pulse that clears the bank selection when power is lost.

The two supply inputs are synchronised and debounced, so noise near a threshold does not cause repeated switching. The cell inputs are only synchronised. The block has no status register for the cells. Their health is sampled once each time full supply returns. If both cells are weak, the block silently drops the second memory cycle of that power session. Software that writes a location and then reads it back will see the write fail, and from this it learns that the cells are weak.

Top module: `pfs_supervisor`

## Requirements
- R1: `acc_en` and `wr_en` stay 0 for every strobe while the filtered full-supply level is low; a strobe with the full-supply level high gives `acc_en`=1 and `wr_en` equal to `cyc_wr`, except as R5 says.
- R2: `src_batt`=1 (backup) while the filtered switchover level is low, and `src_batt`=0 (main) while it is high.
- R3: After reset `acc_en`=0, `wr_en`=0, `src_batt`=1 and `bank_clr`=0.
- R4: Each high-to-low transition of the filtered full-supply level produces exactly one `bank_clr` pulse, one clock long. No pulse occurs at any other time.
- R5: When both cell inputs read low at the moment full supply returns, the strobe numbered `BLOCK_IDX` (default 2, counting from 1 after that return) gets `acc_en`=0 and `wr_en`=0. Earlier and later strobes behave as in R1.
- R6: When at least one cell reads high at that moment, no strobe of the session is blocked.
- R7: The cell result is latched only on the return of full supply. Cell inputs that change later in the session do not change which strobes are blocked.
- R8: `bat_sel`=0 selects cell 1 and 1 selects cell 2. If only cell 1 is above its minimum, cell 1 is selected; if only cell 2 is above, cell 2 is selected. Otherwise the stronger cell is selected, with `bat1_gt_raw`=1 meaning cell 1 is stronger.
- R9: A supply input must hold a new level for `DEB_CYCLES` consecutive synchronised samples before the filtered level follows. A shorter pulse has no effect on `src_batt`, `bank_clr` or access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_hi_raw | input | 1 | Supply above full-operation threshold |
| vcc_lo_raw | input | 1 | Supply above switchover threshold |
| bat1_ok_raw | input | 1 | Cell 1 above minimum |
| bat2_ok_raw | input | 1 | Cell 2 above minimum |
| bat1_gt_raw | input | 1 | Cell 1 stronger than cell 2 |
| cyc_req | input | 1 | One-clock strobe per memory cycle |
| cyc_wr | input | 1 | Strobed cycle is a write |
| acc_en | output | 1 | Cycle allowed to reach the RAM |
| wr_en | output | 1 | Write allowed to reach the RAM |
| src_batt | output | 1 | 1 = RAM powered from backup |
| bat_sel | output | 1 | 0 = cell 1, 1 = cell 2 |
| bank_clr | output | 1 | One-clock bank-selection clear |

## Verification
The assertions assume the comparator inputs are nested: the full-supply input is never high while the switchover input is low. On this basis, backup power implies that no access is allowed. They also assume the cell inputs stay steady around the moment full supply returns. The stimulus raises the switchover input first and lowers it last, with about twenty clocks of settling at each step. It sets the cell inputs before each power-up and changes them during a session only in the test that checks the one-time latch.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic {SRC_MAIN = 1'b0, SRC_BATT = 1'b1} pwr_src_e;
   typedef enum logic {CELL_ONE = 1'b0, CELL_TWO = 1'b1} cell_e;

   function automatic cell_e pick_cell(input logic c1_ok, input logic c2_ok,
                                       input logic c1_gt);
      if (c1_ok && !c2_ok)      return CELL_ONE;
      else if (c2_ok && !c1_ok) return CELL_TWO;
      else                      return c1_gt ? CELL_ONE : CELL_TWO;
   endfunction
endpackage

// File: rtl/pfs_filter.sv
module pfs_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   DEB_CYCLES  = 4,
   parameter logic RST_VAL     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [SYNC_STAGES-1:0] shreg;
   logic                   sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= {SYNC_STAGES{RST_VAL}};
      else        shreg <= {shreg[SYNC_STAGES-2:0], din};
   end
   assign sync_q = shreg[SYNC_STAGES-1];

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pfs_filter: SYNC_STAGES must be at least 2");
      end
      if (DEB_CYCLES == 0) begin : g_bypass
         assign dout = sync_q;
      end else begin : g_debounce
         localparam int CW = $clog2(DEB_CYCLES + 1);
         localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);
         logic [CW-1:0] run_cnt;
         logic          level;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt <= '0;
               level   <= RST_VAL;
            end else if (sync_q == level) begin
               run_cnt <= '0;
            end else if (run_cnt == LAST) begin
               run_cnt <= '0;
               level   <= sync_q;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end
         assign dout = level;
      end
   endgenerate
endmodule

// File: rtl/pfs_batt_mon.sv
module pfs_batt_mon
   import pfs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic c1_ok,
   input  logic c2_ok,
   input  logic c1_gt,
   input  logic sample,
   output logic bat_sel,
   output logic bat_low
);
   cell_e sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= CELL_ONE;
         bat_low <= 1'b0;
      end else begin
         sel_q <= pick_cell(c1_ok, c2_ok, c1_gt);
         if (sample) bat_low <= !(c1_ok || c2_ok);
      end
   end
   assign bat_sel = sel_q;
endmodule

// File: rtl/pfs_cycle_gate.sv
module pfs_cycle_gate #(
   parameter int BLOCK_IDX = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic pwr_ok,
   input  logic bat_low,
   input  logic cyc_req,
   input  logic cyc_wr,
   output logic acc_en,
   output logic wr_en
);
   localparam int CW = $clog2(BLOCK_IDX + 1);
   localparam logic [CW-1:0] SAT  = CW'(BLOCK_IDX);
   localparam logic [CW-1:0] HOLE = CW'(BLOCK_IDX - 1);

   generate
      if (BLOCK_IDX < 1) begin : g_bad_idx
         $error("pfs_cycle_gate: BLOCK_IDX must be at least 1");
      end
   endgenerate

   logic [CW-1:0] seen;
   logic          blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               seen <= '0;
      else if (restart)                         seen <= '0;
      else if (cyc_req && pwr_ok && seen != SAT) seen <= seen + 1'b1;
   end

   assign blocked = bat_low && (seen == HOLE);
   assign acc_en  = cyc_req && pwr_ok && !blocked;
   assign wr_en   = acc_en && cyc_wr;
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
   import pfs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 4,
   parameter int BLOCK_IDX   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_hi_raw,
   input  logic vcc_lo_raw,
   input  logic bat1_ok_raw,
   input  logic bat2_ok_raw,
   input  logic bat1_gt_raw,
   input  logic cyc_req,
   input  logic cyc_wr,
   output logic acc_en,
   output logic wr_en,
   output logic src_batt,
   output logic bat_sel,
   output logic bank_clr
);
   generate
      if (DEB_CYCLES < 2) begin : g_bad_deb
         $error("pfs_supervisor: DEB_CYCLES must be at least 2");
      end
   endgenerate

   logic hi_good, lo_good, b1_f, b2_f, gt_f;
   logic hi_d, hi_rise, bat_low;

   pfs_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES), .RST_VAL(1'b0))
      u_hi (.clk(clk), .rst_n(rst_n), .din(vcc_hi_raw), .dout(hi_good));
   pfs_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES), .RST_VAL(1'b0))
      u_lo (.clk(clk), .rst_n(rst_n), .din(vcc_lo_raw), .dout(lo_good));
   pfs_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(0), .RST_VAL(1'b0))
      u_b1 (.clk(clk), .rst_n(rst_n), .din(bat1_ok_raw), .dout(b1_f));
   pfs_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(0), .RST_VAL(1'b0))
      u_b2 (.clk(clk), .rst_n(rst_n), .din(bat2_ok_raw), .dout(b2_f));
   pfs_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(0), .RST_VAL(1'b0))
      u_gt (.clk(clk), .rst_n(rst_n), .din(bat1_gt_raw), .dout(gt_f));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_d <= 1'b0;
      else        hi_d <= hi_good;
   end
   assign hi_rise  = hi_good && !hi_d;
   assign bank_clr = hi_d && !hi_good;
   assign src_batt = lo_good ? SRC_MAIN : SRC_BATT;

   pfs_batt_mon u_bat (
      .clk(clk), .rst_n(rst_n), .c1_ok(b1_f), .c2_ok(b2_f), .c1_gt(gt_f),
      .sample(hi_rise), .bat_sel(bat_sel), .bat_low(bat_low));

   pfs_cycle_gate #(.BLOCK_IDX(BLOCK_IDX)) u_gate (
      .clk(clk), .rst_n(rst_n), .restart(hi_rise), .pwr_ok(hi_good),
      .bat_low(bat_low), .cyc_req(cyc_req), .cyc_wr(cyc_wr),
      .acc_en(acc_en), .wr_en(wr_en));
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic hi_good,
   input logic b1_f,
   input logic b2_f,
   input logic bat_low,
   input logic acc_en,
   input logic wr_en,
   input logic src_batt,
   input logic bat_sel,
   input logic bank_clr
);
   assert_no_access_low_vcc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_good |-> !acc_en);
   assert_write_needs_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> acc_en);
   assert_backup_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      src_batt |-> !acc_en);
   assert_clr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_clr |=> !bank_clr);
   assert_clr_when_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_clr |-> !hi_good);
   assert_latch_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_good && $past(hi_good) && $past(hi_good, 2)) |-> $stable(bat_low));
   assert_only_cell1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (b1_f && !b2_f) |=> !bat_sel);
   assert_only_cell2_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (b2_f && !b1_f) |=> bat_sel);
   assert_src_debounced_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(src_batt) |=> $stable(src_batt));
endmodule

bind pfs_supervisor pfs_supervisor_chk chk_i (
   .clk(clk), .rst_n(rst_n), .hi_good(hi_good), .b1_f(b1_f), .b2_f(b2_f),
   .bat_low(bat_low), .acc_en(acc_en), .wr_en(wr_en), .src_batt(src_batt),
   .bat_sel(bat_sel), .bank_clr(bank_clr));

// File: tb/pfs_supervisor_tb_top.sv
module pfs_supervisor_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vcc_hi_raw = 0, vcc_lo_raw = 0, bat1_ok_raw = 0, bat2_ok_raw = 0, bat1_gt_raw = 0;
   logic cyc_req = 0, cyc_wr = 0;
   logic acc_en, wr_en, src_batt, bat_sel, bank_clr;

   int n_chk = 0, n_fail = 0, clr_pulses = 0;
   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   pfs_supervisor dut_i (
      .clk(clk), .rst_n(rst_n), .vcc_hi_raw(vcc_hi_raw), .vcc_lo_raw(vcc_lo_raw),
      .bat1_ok_raw(bat1_ok_raw), .bat2_ok_raw(bat2_ok_raw), .bat1_gt_raw(bat1_gt_raw),
      .cyc_req(cyc_req), .cyc_wr(cyc_wr), .acc_en(acc_en), .wr_en(wr_en),
      .src_batt(src_batt), .bat_sel(bat_sel), .bank_clr(bank_clr));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: queue expected {acc_en, wr_en}, then issue the strobe
   task automatic mem_cycle(input logic wr, input logic allow, input string tag);
      exp_q.push_back({allow, allow & wr});
      tag_q.push_back(tag);
      @(negedge clk); cyc_req <= 1'b1; cyc_wr <= wr;
      @(negedge clk); cyc_req <= 1'b0; cyc_wr <= 1'b0;
      settle(2);
   endtask

   // monitor
   always @(negedge clk) begin
      #2;
      if (bank_clr) clr_pulses++;
      if (cyc_req) begin
         if (exp_q.size() == 0) check("queue", 1, 0);
         else begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {acc_en, wr_en}, e);
         end
      end
   end

   task automatic power_up;
      vcc_lo_raw = 1'b1; settle(20);
      vcc_hi_raw = 1'b1; settle(20);
   endtask

   task automatic power_down;
      vcc_hi_raw = 1'b0; settle(20);
      vcc_lo_raw = 1'b0; settle(20);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      settle(3);
      check("R3 acc_en", acc_en, 0);
      check("R3 wr_en", wr_en, 0);
      check("R3 src_batt", src_batt, 1);
      check("R3 bank_clr", bank_clr, 0);
      rst_n = 1'b1;
      settle(5);

      // R1: no supply, strobes ignored
      mem_cycle(1'b1, 1'b0, "R1 write while down");
      // R2: switchover level only
      bat1_ok_raw = 1; bat2_ok_raw = 1; bat1_gt_raw = 1;
      vcc_lo_raw = 1'b1; settle(20);
      check("R2 main src", src_batt, 0);
      mem_cycle(1'b0, 1'b0, "R1 read below full level");
      vcc_hi_raw = 1'b1; settle(20);
      // R6: healthy cells, nothing blocked
      mem_cycle(1'b1, 1'b1, "R6 cycle1");
      mem_cycle(1'b1, 1'b1, "R6 cycle2");
      mem_cycle(1'b0, 1'b1, "R1 cycle3 read");
      // R9: short glitches do nothing
      vcc_lo_raw = 1'b0; settle(2); vcc_lo_raw = 1'b1; settle(15);
      check("R9 src unchanged", src_batt, 0);
      vcc_hi_raw = 1'b0; settle(2); vcc_hi_raw = 1'b1; settle(15);
      check("R9 no clr pulse", clr_pulses, 0);
      mem_cycle(1'b1, 1'b1, "R9 access kept");
      // R4: power loss clears banks once
      power_down;
      check("R4 one clr pulse", clr_pulses, 1);
      check("R2 backup src", src_batt, 1);

      // R5: both cells weak
      bat1_ok_raw = 0; bat2_ok_raw = 0; settle(5);
      power_up;
      mem_cycle(1'b0, 1'b1, "R5 cycle1 read");
      mem_cycle(1'b1, 1'b0, "R5 cycle2 blocked");
      mem_cycle(1'b0, 1'b1, "R5 cycle3 read");
      mem_cycle(1'b1, 1'b1, "R5 cycle4 write");
      power_down;
      check("R4 second clr pulse", clr_pulses, 2);

      // R6: one weak cell only
      bat1_ok_raw = 0; bat2_ok_raw = 1; settle(5);
      power_up;
      mem_cycle(1'b1, 1'b1, "R6 one cell cycle1");
      mem_cycle(1'b1, 1'b1, "R6 one cell cycle2");
      power_down;

      // R7: cells fail after power-up, not re-sampled
      bat1_ok_raw = 1; bat2_ok_raw = 1; settle(5);
      power_up;
      mem_cycle(1'b1, 1'b1, "R7 cycle1");
      bat1_ok_raw = 0; bat2_ok_raw = 0; settle(10);
      mem_cycle(1'b1, 1'b1, "R7 cycle2 not blocked");

      // R8: cell selection
      bat1_ok_raw = 1; bat2_ok_raw = 0; bat1_gt_raw = 0; settle(10);
      check("R8 only cell1", bat_sel, 0);
      bat1_ok_raw = 0; bat2_ok_raw = 1; bat1_gt_raw = 1; settle(10);
      check("R8 only cell2", bat_sel, 1);
      bat1_ok_raw = 1; bat2_ok_raw = 1; bat1_gt_raw = 0; settle(10);
      check("R8 cell2 stronger", bat_sel, 1);
      bat1_gt_raw = 1; settle(10);
      check("R8 cell1 stronger", bat_sel, 0);

      settle(5);
      check("queue drained", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule